// File: doc/BRIEF.md
# H-Bridge Drive Controller with Fault Latch

This block turns two direction lines and two disable lines into drive commands for a two-leg bridge. Each leg has a high-side enable and a low-side enable, and a leg can be pulled up, pulled down or left floating with both switches off. The block also watches four fault indications: supply too low, die too hot, overcurrent, and current limiting in progress. It drives an active-low status flag that a host reads as an open-drain line.

Faults from overtemperature and overcurrent are held after the cause goes away. They clear only on a particular edge of a host-controlled line. A mode strap picks which lines give that edge. With the strap low, the disable lines do, and the disable lines also float the bridge and pull the flag. With the strap high, the direction lines give the edge and the disable lines have no effect.

Every input passes through a two-stage synchronizer before it is used. Each leg waits a programmable dead time before it swaps from one switch to the other.

Top module: `hbridge_ctrl`

## Requirements
- R1: With no fault or disable active, leg A follows dir_a and leg B follows dir_b. A line at 1 gives high-side on and low-side off, and a line at 0 gives low-side on and high-side off. So (dir_a,dir_b)=(1,0) drives forward, (0,1) reverse, (0,0) both low and (1,1) both high.
- R2: With strap=0, dis_a=1 or dis_b=0 turns all four enables off and drives flag_n to 0.
- R3: With strap=1, dis_a and dis_b have no effect on the enables or on flag_n.
- R4: An asserted oc or ot turns all enables off and drives flag_n to 0. The fault stays stored after the input returns to 0.
- R5: With strap=0, a stored fault clears on a 1-to-0 change of dis_a or a 0-to-1 change of dis_b. Edges on the direction lines do not clear it.
- R6: With strap=1, a stored fault clears on a 1-to-0 change of dir_a or a 0-to-1 change of dir_b. Edges on the disable lines do not clear it.
- R7: A release edge clears a stored overtemperature fault only if ot is 0 at that time. Otherwise the fault stays stored, and a later edge is needed once ot is 0.
- R8: uv=1 turns all enables off and drives flag_n to 0. When uv returns to 0, enables and flag return to normal with no release edge.
- R9: ilim=1 turns all enables off while flag_n stays 1.
- R10: No leg ever has its high and low enables on in the same cycle. Between one side turning off and the opposite side turning on, the leg stays fully off for at least DEAD_CYC cycles.
- R11: During reset all enables are 0, flag_n is 1 and no fault is stored.
- R12: An input change reaches the outputs on the third rising clock edge after it is applied. Two edges come from synchronizing and one from the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction line for leg A |
| dir_b | input | 1 | Direction line for leg B |
| dis_a | input | 1 | Disable line, active high |
| dis_b | input | 1 | Disable line, active low |
| strap | input | 1 | Mode strap selecting the release source |
| uv | input | 1 | Supply undervoltage indication |
| ot | input | 1 | Overtemperature indication |
| oc | input | 1 | Overcurrent indication |
| ilim | input | 1 | Current limiting active |
| hs_a | output | 1 | Leg A high-side enable |
| ls_a | output | 1 | Leg A low-side enable |
| hs_b | output | 1 | Leg B high-side enable |
| ls_b | output | 1 | Leg B low-side enable |
| flag_n | output | 1 | Status flag, active low |

## Verification
The bench builds the block with DEAD_CYC=5 and the default two synchronizer stages. The longer dead time makes each floating gap on a direction swap span more cycles than the input-to-output latency. That lets the bench's per-leg gap monitor tell a correct gap from one cut short by a cycle or two. Random steps mix strap changes, disable toggles and brief fault pulses. This reaches release edges that arrive together with a new fault, or under the strap setting that should ignore them.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[g] <= '0;
          else        st_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[g] <= '0;
          else        st_q[g] <= st_q[g-1];
        end
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_in,
  input  logic ot_in,
  input  logic release_ev,
  output logic oc_held,
  output logic ot_held
);
  logic oc_q, ot_q, oc_d, ot_d;

  always_comb begin
    oc_d = oc_in | (oc_q & ~release_ev);
    ot_d = ot_in | (ot_q & ~release_ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q <= 1'b0;
      ot_q <= 1'b0;
    end else begin
      oc_q <= oc_d;
      ot_q <= ot_d;
    end
  end

  assign oc_held = oc_q;
  assign ot_held = ot_q;

  assert_fault_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q && !release_ev) |=> oc_q);
  assert_hot_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && ot_in) |=> ot_q);
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_t req,
  output logic hs,
  output logic ls
);
  localparam int CW = $clog2(DEAD_CYC + 1);

  leg_t          cur_q, cur_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cur_d  = cur_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (req != cur_q && cur_q != LEG_OFF) begin
      cur_d  = LEG_OFF;
      cnt_d  = CW'(DEAD_CYC);
      cnt_en = 1'b1;
    end else if (cur_q == LEG_OFF) begin
      if (cnt_q == '0) begin
        cur_d = req;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LEG_OFF;
      cnt_q <= '0;
    end else begin
      cur_q <= cur_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hs = (cur_q == LEG_HI);
  assign ls = (cur_q == LEG_LO);

  assert_no_shoot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs && ls));
  assert_gap_hl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> !ls);
  assert_gap_lh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ls |=> !hs);
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a,
  input  logic dir_b,
  input  logic dis_a,
  input  logic dis_b,
  input  logic strap,
  input  logic uv,
  input  logic ot,
  input  logic oc,
  input  logic ilim,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic flag_n
);
  localparam int NIN    = 9;
  localparam int NEDGE  = 4;
  localparam int NLEG   = 2;
  localparam int I_DIRA = 0;
  localparam int I_DIRB = 1;
  localparam int I_DISA = 2;
  localparam int I_DISB = 3;
  localparam int I_OC   = 4;
  localparam int I_OT   = 5;
  localparam int I_UV   = 6;
  localparam int I_ILIM = 7;
  localparam int I_STRP = 8;

  logic [NIN-1:0]   raw, syn;
  logic [NEDGE-1:0] prev_q;
  logic             release_ev, oc_held, ot_held;
  logic             dis_act, stored, hold, flag_bad, flag_q;
  leg_t             req [NLEG];
  logic [NLEG-1:0]  hs_v, ls_v, dir_v;

  assign raw = {strap, ilim, uv, ot, oc, dis_b, dis_a, dir_b, dir_a};

  hb_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= syn[NEDGE-1:0];
  end

  always_comb begin
    if (syn[I_STRP])
      release_ev = (prev_q[I_DIRA] & ~syn[I_DIRA]) | (~prev_q[I_DIRB] & syn[I_DIRB]);
    else
      release_ev = (prev_q[I_DISA] & ~syn[I_DISA]) | (~prev_q[I_DISB] & syn[I_DISB]);
  end

  hb_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .oc_in(syn[I_OC]), .ot_in(syn[I_OT]), .release_ev(release_ev),
    .oc_held(oc_held), .ot_held(ot_held)
  );

  always_comb begin
    dis_act  = ~syn[I_STRP] & (syn[I_DISA] | ~syn[I_DISB]);
    stored   = oc_held | ot_held | syn[I_OC] | syn[I_OT];
    flag_bad = dis_act | stored | syn[I_UV];
    hold     = flag_bad | syn[I_ILIM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= ~flag_bad;
  end

  assign dir_v = {syn[I_DIRB], syn[I_DIRA]};

  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      always_comb begin
        if (hold)          req[g] = LEG_OFF;
        else if (dir_v[g]) req[g] = LEG_HI;
        else               req[g] = LEG_LO;
      end
      hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
        .clk(clk), .rst_n(rst_n), .req(req[g]), .hs(hs_v[g]), .ls(ls_v[g])
      );
    end
  endgenerate

  assign hs_a   = hs_v[0];
  assign ls_a   = ls_v[0];
  assign hs_b   = hs_v[1];
  assign ls_b   = ls_v[1];
  assign flag_n = flag_q;

  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !(hs_a | ls_a | hs_b | ls_b));
  assert_uv_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    syn[I_UV] |=> !flag_n);
  assert_ilim_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (syn[I_ILIM] && !flag_bad) |=> flag_n);
  assert_strap_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (syn[I_STRP] && !stored && !syn[I_UV]) |=> flag_n);
endmodule

// File: tb/test_hbridge_ctrl.sv
`timescale 1ns/1ps
module test_hbridge_ctrl;
  localparam int DEAD = 5;
  localparam int SETTLE = DEAD + 10;

  logic clk, rst_n;
  logic dir_a, dir_b, dis_a, dis_b, strap, uv, ot, oc, ilim;
  logic hs_a, ls_a, hs_b, ls_b, flag_n;

  int total = 0;
  int bad   = 0;
  logic m_oc = 1'b0;
  logic m_ot = 1'b0;

  hbridge_ctrl #(.DEAD_CYC(DEAD), .SYNC_STAGES(2)) i_hbridge_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .dis_a(dis_a),
    .dis_b(dis_b), .strap(strap), .uv(uv), .ot(ot), .oc(oc), .ilim(ilim),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .flag_n(flag_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector layout: {strap, dis_a, dis_b, dir_a, dir_b, uv, ilim, ot, oc}
  function automatic logic [4:0] expect_out(input logic [8:0] v, input logic lo, input logic lt);
    logic dis, hold, fb;
    dis  = !v[8] && (v[7] || !v[6]);
    fb   = dis || v[3] || lo || lt || v[0] || v[1];
    hold = fb || v[2];
    if (hold) return {4'b0000, !fb};
    return {v[5], !v[5], v[4], !v[4], 1'b1};
  endfunction

  task automatic check(input logic [4:0] exp, input string req);
    logic [4:0] act;
    act = {hs_a, ls_a, hs_b, ls_b, flag_n};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] cur_vec();
    return {strap, dis_a, dis_b, dir_a, dir_b, uv, ilim, ot, oc};
  endfunction

  task automatic apply(input logic [8:0] v, input int wait_cyc);
    logic [8:0] o;
    logic rel;
    o = cur_vec();
    if (v[8]) rel = (o[5] && !v[5]) || (!o[4] && v[4]);
    else      rel = (o[7] && !v[7]) || (!o[6] && v[6]);
    m_oc = v[0] || (m_oc && !rel);
    m_ot = v[1] || (m_ot && !rel);
    @(negedge clk);
    {strap, dis_a, dis_b, dir_a, dir_b, uv, ilim, ot, oc} = v;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic step_check(input logic [8:0] v, input string req);
    apply(v, SETTLE);
    check(expect_out(v, m_oc, m_ot), req);
  endtask

  // Per-leg dead-time monitor (R10)
  int   offc [2];
  int   lastd [2];
  always @(negedge clk) begin
    logic [1:0] hv, lv;
    hv = {hs_b, hs_a};
    lv = {ls_b, ls_a};
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin offc[k] = 0; lastd[k] = 0; end
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (hv[k] && lv[k]) begin
          total++; bad++;
          $display("FAIL R10: leg %0d both sides on, got 11 expected not 11", k);
        end else if (hv[k] || lv[k]) begin
          int side;
          side = hv[k] ? 1 : 2;
          if (lastd[k] != 0 && lastd[k] != side) begin
            total++;
            if (offc[k] < DEAD) begin
              bad++;
              $display("FAIL R10: leg %0d gap %0d expected >= %0d", k, offc[k], DEAD);
            end
          end
          lastd[k] = side;
          offc[k] = 0;
        end else begin
          offc[k] = offc[k] + 1;
        end
      end
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] v;
    void'($urandom(1234));
    {strap, dis_a, dis_b, dir_a, dir_b, uv, ilim, ot, oc} = 9'b0_0_1_1_0_0_0_0_0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(5'b00001, "R11 reset");
    rst_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    check(expect_out(cur_vec(), m_oc, m_ot), "R1 forward after reset");

    // R1 direction combos, strap low, enabled
    step_check(9'b0_0_1_0_1_0_0_0_0, "R1 reverse");
    step_check(9'b0_0_1_0_0_0_0_0_0, "R1 both low");
    step_check(9'b0_0_1_1_1_0_0_0_0, "R1 both high");
    step_check(9'b0_0_1_1_0_0_0_0_0, "R1 forward");

    // R12 latency using undervoltage recovery
    apply(9'b0_0_1_1_0_1_0_0_0, SETTLE);
    check(5'b00000, "R8 undervoltage off");
    @(negedge clk); uv = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(5'b00000, "R12 unchanged after two edges");
    @(posedge clk); @(negedge clk);
    check(5'b10011, "R12 changed on third edge");
    repeat (SETTLE) @(negedge clk);
    check(5'b10011, "R8 auto recovery");

    // R2 / R3 disable handling
    step_check(9'b0_1_1_1_0_0_0_0_0, "R2 dis_a high");
    step_check(9'b0_0_0_1_0_0_0_0_0, "R2 dis_b low");
    step_check(9'b1_1_0_1_0_0_0_0_0, "R3 strap high ignores disables");
    step_check(9'b0_0_1_1_0_0_0_0_0, "R3 strap low normal");

    // R4 / R5 overcurrent with strap low
    apply(9'b0_0_1_1_0_0_0_0_1, 4);
    step_check(9'b0_0_1_1_0_0_0_0_0, "R4 overcurrent stored");
    step_check(9'b0_0_1_0_0_0_0_0_0, "R5 dir edge ignored when strap low");
    step_check(9'b0_1_1_0_1_0_0_0_0, "R5 disable raised");
    step_check(9'b0_0_1_0_1_0_0_0_0, "R5 dis_a fall releases");

    // R6 strap high release via direction lines
    apply(9'b1_0_1_1_0_0_0_0_1, 4);
    step_check(9'b1_0_1_1_0_0_0_0_0, "R6 stored with strap high");
    step_check(9'b1_0_0_1_0_0_0_0_0, "R6 dis_b low");
    step_check(9'b1_0_1_1_0_0_0_0_0, "R6 dis_b rise ignored");
    step_check(9'b1_0_1_0_0_0_0_0_0, "R6 dir_a fall releases");

    // R7 overtemperature release gated by temperature
    apply(9'b0_0_1_1_0_0_0_1_0, 4);
    step_check(9'b0_1_1_1_0_0_0_1_0, "R7 hot, disable up");
    step_check(9'b0_0_1_1_0_0_0_1_0, "R7 edge while hot keeps fault");
    step_check(9'b0_0_1_1_0_0_0_0_0, "R7 cooled but no edge");
    step_check(9'b0_0_0_1_0_0_0_0_0, "R7 dis_b low");
    step_check(9'b0_0_1_1_0_0_0_0_0, "R7 dis_b rise releases");

    // R9 current limiting
    step_check(9'b0_0_1_0_1_0_1_0_0, "R9 ilim off, flag high");
    step_check(9'b0_0_1_0_1_0_0_0_0, "R9 ilim ends");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      v[8] = ($urandom % 4) == 0;
      v[7] = ($urandom % 5) == 0;
      v[6] = ($urandom % 5) != 0;
      v[5] = $urandom % 2;
      v[4] = $urandom % 2;
      v[3] = ($urandom % 10) == 0;
      v[2] = ($urandom % 10) == 0;
      v[1] = ($urandom % 12) == 0;
      v[0] = ($urandom % 12) == 0;
      step_check(v, "R1-mix random step (R4 R5 R6 R7)");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule